// File: doc/BRIEF.md
# AXI3 Burst Write Master

This block moves data from a wide on-chip line buffer into host memory over the write half of an AXI3 port. A single-cycle start request supplies a destination byte address, a byte count and a pair of coherency attribute values. The block then writes the region as a series of full 16-beat incrementing bursts. Each burst carries exactly one buffer block. Block 0 goes to the first burst, block 1 to the second, and so on. The block index wraps at the end of the buffer.

Only one burst is in flight at a time. The address phase goes out first. The sixteen data beats follow, read one word ahead from the buffer. The block then waits for the write response before it moves the address on by one burst. When the last response arrives, the block pulses `done`. A non-OKAY response sets a sticky error flag, and the transfer runs on to the end. Bursts whose address falls in the fixed coherent window carry the programmed cache and user attributes. All other bursts carry plain ones.

The bus width is a parameter and may be 128 or 256 bits. The burst size in bytes is sixteen times the beat width.

Top module: `axi3_block_writer`

## Requirements
- R1: A start request is taken only while `busy` is low. `busy` goes high in the cycle after a taken start and stays high until `done` pulses. A start request while `busy` is high has no effect on addresses, data or attributes.
- R2: Every burst has AWLEN = 15, AWBURST = 2'b01 (incrementing) and AWSIZE = log2(DATA_W/8), so 4 for 128 bits and 5 for 256 bits. WSTRB is all ones. WLAST is high on the 16th beat of a burst and low on every other beat.
- R3: The first burst goes to `start_addr` with its low log2(burst bytes) bits cleared. Each following burst goes one burst size higher. No burst crosses a 4 KB boundary.
- R4: The number of bursts is `length_bytes` divided by the burst size, and any remainder is dropped. A new address phase is issued only after the write response of the previous burst has been accepted. Data beats are issued only after their address phase has been accepted.
- R5: Burst k of a transfer (counting from 0) sends beat j from buffer word ((k mod 2^BLK_W) * 16 + j). The buffer returns a word the cycle after `buf_rd_en` and holds it while `buf_rd_en` is low.
- R6: While `wready` is low, `wvalid` stays high and `wdata` stays unchanged. While `awready` is low, `awvalid` stays high and `awaddr` stays unchanged.
- R7: When address bits [31:30] of a burst are 2'b10 (0x80000000 to 0xBFFFFFFF), AWCACHE and AWUSER equal the `coh_cache` and `coh_user` values captured at the taken start. For any other burst they are 4'b0000 and 0. Changes to `coh_cache` or `coh_user` during a transfer have no effect.
- R8: `done` is high for one cycle, in the cycle after the final write response handshake. If the burst count is zero, `done` is high in the cycle after the taken start, no address phase is issued and `busy` stays low.
- R9: `err` goes high in the cycle after a response handshake with BRESP other than 2'b00. It stays high until the next taken start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request |
| start_addr | input | ADDR_W | Destination byte address |
| length_bytes | input | LEN_W | Transfer size in bytes |
| coh_cache | input | 4 | AWCACHE value for coherent-window bursts |
| coh_user | input | USER_W | AWUSER value for coherent-window bursts |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky bad-response flag |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | BLK_W+4 | Buffer word address (block, beat) |
| buf_rd_data | input | DATA_W | Buffer read data, one-cycle latency |
| awid | output | ID_W | Write address ID (constant) |
| awaddr | output | ADDR_W | Burst address |
| awlen | output | 4 | Burst length minus one |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type |
| awcache | output | 4 | Cache attributes |
| awuser | output | USER_W | User sideband |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address ready |
| wid | output | ID_W | Write data ID (constant) |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Last beat of burst |
| wvalid | output | 1 | Data valid |
| wready | input | 1 | Data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |

## Verification
The first stimulus is a short aligned transfer against a slave that never stalls. It fixes the base addressing, the beat order and the done timing. A later run repeats the work with random stalls on all three channels and an unaligned start with a trailing remainder. This run separates correct holding of valid and data from beat skipping, and separates address truncation from count truncation. A transfer that starts just below the top of the coherent window shows whether attributes are chosen per burst. Attribute inputs change mid-run, so the same transfer also shows whether they are latched at start. A ten-burst run exercises block wrap, an injected error response and an ignored mid-transfer start. A final sub-burst length checks the zero-count path and the clearing of the error flag.

// File: rtl/axi3_block_writer.sv
module axi3_block_writer #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 32,
  parameter int LEN_W = 32,
  parameter int BLK_W = 3,
  parameter int ID_W = 4,
  parameter int USER_W = 5,
  parameter logic [ID_W-1:0] WR_ID = '0,
  parameter logic [3:0] PLAIN_CACHE = 4'b0000,
  parameter int WIN_LG = 30,
  parameter logic [1:0] WIN_TAG = 2'b10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [LEN_W-1:0]    length_bytes,
  input  logic [3:0]          coh_cache,
  input  logic [USER_W-1:0]   coh_user,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                buf_rd_en,
  output logic [BLK_W+3:0]    buf_rd_addr,
  input  logic [DATA_W-1:0]   buf_rd_data,
  output logic [ID_W-1:0]     awid,
  output logic [ADDR_W-1:0]   awaddr,
  output logic [3:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic [3:0]          awcache,
  output logic [USER_W-1:0]   awuser,
  output logic                awvalid,
  input  logic                awready,
  output logic [ID_W-1:0]     wid,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready
);

  localparam int BEAT_BYTES  = DATA_W / 8;
  localparam int SIZE_CODE   = $clog2(BEAT_BYTES);
  localparam int BURST_BYTES = BEAT_BYTES * 16;
  localparam int BB_LG       = $clog2(BURST_BYTES);
  localparam int CNT_W       = LEN_W - BB_LG;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

  generate
    if (DATA_W != 128 && DATA_W != 256) begin : g_bad_width
      $error("DATA_W must be 128 or 256");
    end
  endgenerate

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_LOAD, S_DATA, S_RESP} state_t;

  state_t            st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [BLK_W-1:0]  blk_q;
  logic [3:0]        beat_q;
  logic [3:0]        cache_q;
  logic [USER_W-1:0] user_q;
  logic              done_q, err_q;

  wire [CNT_W-1:0] nburst = CNT_W'(length_bytes >> BB_LG);
  wire aw_hs  = awvalid && awready;
  wire w_hs   = wvalid && wready;
  wire b_hs   = bvalid && bready;
  wire last_b = (beat_q == 4'd15);
  wire in_win = (addr_q[WIN_LG +: 2] == WIN_TAG);

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign awid    = WR_ID;
  assign wid     = WR_ID;
  assign awaddr  = addr_q;
  assign awlen   = 4'd15;
  assign awsize  = 3'(SIZE_CODE);
  assign awburst = 2'b01;
  assign awcache = in_win ? cache_q : PLAIN_CACHE;
  assign awuser  = in_win ? user_q : '0;
  assign awvalid = (st == S_ADDR);
  assign wvalid  = (st == S_DATA);
  assign wlast   = wvalid && last_b;
  assign wdata   = buf_rd_data;
  assign wstrb   = '1;
  assign bready  = (st == S_RESP);

  assign buf_rd_en   = (st == S_LOAD) || (w_hs && !last_b);
  assign buf_rd_addr = {blk_q, (st == S_LOAD) ? 4'd0 : beat_q + 4'd1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      blk_q   <= '0;
      beat_q  <= '0;
      cache_q <= '0;
      user_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err_q   <= 1'b0;
          addr_q  <= start_addr & ~(STEP - 1'b1);
          left_q  <= nburst;
          blk_q   <= '0;
          cache_q <= coh_cache;
          user_q  <= coh_user;
          if (nburst == '0) done_q <= 1'b1;
          else              st     <= S_ADDR;
        end
        S_ADDR: if (awready) begin
          st     <= S_LOAD;
          beat_q <= '0;
        end
        S_LOAD: st <= S_DATA;
        S_DATA: if (wready) begin
          if (last_b) st <= S_RESP;
          else        beat_q <= beat_q + 4'd1;
        end
        S_RESP: if (bvalid) begin
          if (bresp != 2'b00) err_q <= 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st     <= S_ADDR;
            addr_q <= addr_q + STEP;
            blk_q  <= blk_q + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [3:0] chk_beats;
  logic       chk_open;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_beats <= '0;
      chk_open  <= 1'b0;
    end else begin
      if (aw_hs)     chk_beats <= '0;
      else if (w_hs) chk_beats <= chk_beats + 4'd1;
      if (aw_hs)     chk_open <= 1'b1;
      else if (b_hs) chk_open <= 1'b0;
    end
  end

  assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata));
  assert_last_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    w_hs |-> (wlast == (chk_beats == 4'd15)));
  assert_one_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> !chk_open);
  assert_no_4k_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> ({1'b0, awaddr[11:0]} + 13'(BURST_BYTES)) <= 13'd4096);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !buf_rd_en && !awvalid && !wvalid);

endmodule

// File: tb/sim_axi3_block_writer.sv
`timescale 1ns/1ps
module sim_axi3_block_writer;
  localparam int DW = 128;
  localparam int BLKW = 3;
  localparam int BB = DW / 8 * 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [31:0] start_addr = 0, length_bytes = 0;
  logic [3:0] coh_cache = 0;
  logic [4:0] coh_user = 0;
  logic busy, done, err, buf_rd_en;
  logic [BLKW+3:0] buf_rd_addr;
  logic [DW-1:0] buf_rd_data = '0;
  logic [3:0] awid, wid, awlen, awcache;
  logic [31:0] awaddr;
  logic [2:0] awsize;
  logic [1:0] awburst;
  logic [4:0] awuser;
  logic awvalid, awready = 0, wlast, wvalid, wready = 0, bvalid = 0, bready;
  logic [DW-1:0] wdata;
  logic [DW/8-1:0] wstrb;
  logic [1:0] bresp = 0;

  axi3_block_writer #(.DATA_W(DW), .BLK_W(BLKW)) u0 (
    .clk, .rst_n, .start, .start_addr, .length_bytes, .coh_cache, .coh_user,
    .busy, .done, .err, .buf_rd_en, .buf_rd_addr, .buf_rd_data,
    .awid, .awaddr, .awlen, .awsize, .awburst, .awcache, .awuser, .awvalid, .awready,
    .wid, .wdata, .wstrb, .wlast, .wvalid, .wready, .bresp, .bvalid, .bready);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  task automatic check(bit ok, string r, logic [255:0] act, logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int idx);
    for (int i = 0; i < DW/32; i++) pat[i*32 +: 32] = 32'h5A5A_0000 ^ {16'(idx), 16'(i)};
  endfunction

  always @(posedge clk) if (buf_rd_en) buf_rd_data <= pat(int'(buf_rd_addr));

  bit throttle = 0;
  int err_at = -1;
  bit m_busy = 0, exp_done = 0, exp_err = 0;
  logic [31:0] m_base;
  int m_nb, m_k, m_bk, beat, b_pend, b_wait, b_issued;
  logic [3:0] m_cache;
  logic [4:0] m_user;
  bit open_b, aw_open, b_took;
  bit pw_v, pw_r, pa_v, pa_r;
  logic [DW-1:0] pw_d;
  logic [31:0] pa_a;

  always @(negedge clk) begin
    if (rst_n) begin
      check(busy === m_busy, "R1 busy", busy, m_busy);
      check(done === exp_done, "R8 done", done, exp_done);
      check(err === exp_err, "R9 err", err, exp_err);
    end
    if (b_took) bvalid = 0;
    b_took = 0;
    if (!bvalid && b_pend > 0) begin
      if (b_wait > 0) b_wait--;
      else begin
        bvalid = 1;
        bresp = (b_issued == err_at) ? 2'b10 : 2'b00;
        b_issued++;
        b_pend--;
      end
    end
    awready = throttle ? ($urandom % 3 != 0) : 1'b1;
    wready  = throttle ? ($urandom % 4 != 0) : 1'b1;
    #1;
    if (rst_n) begin
      bit nb_busy, n_done, n_err;
      nb_busy = m_busy; n_done = 0; n_err = exp_err;
      if (start && !m_busy) begin
        m_base = start_addr & ~32'(BB - 1);
        m_nb = int'(length_bytes / BB);
        m_k = 0; m_bk = 0; m_cache = coh_cache; m_user = coh_user;
        n_err = 0;
        if (m_nb == 0) n_done = 1; else nb_busy = 1;
      end
      if (pa_v && !pa_r) check(awvalid && awaddr == pa_a, "R6 aw hold", awaddr, pa_a);
      if (pw_v && !pw_r) check(wvalid && wdata == pw_d, "R6 w hold", wdata, pw_d);
      if (awvalid) begin
        check(!open_b && !aw_open, "R4 aw while open", open_b, 0);
        if (awready) begin
          logic [31:0] ea;
          bit win;
          ea = m_base + 32'(m_k * BB);
          win = (ea[31:30] == 2'b10);
          check(awaddr == ea, "R3 awaddr", awaddr, ea);
          check(awlen == 15 && awburst == 2'b01 && awsize == 3'($clog2(DW/8)), "R2 aw fields",
                {awlen, awburst, awsize}, {4'd15, 2'b01, 3'($clog2(DW/8))});
          check(awcache == (win ? m_cache : 4'h0), "R7 awcache", awcache, win ? m_cache : 4'h0);
          check(awuser == (win ? m_user : 5'h0), "R7 awuser", awuser, win ? m_user : 5'h0);
          check(m_k < m_nb, "R4 burst count", m_k, m_nb);
          aw_open = 1; beat = 0;
        end
      end
      if (wvalid) begin
        check(aw_open, "R4 w before aw", aw_open, 1);
        check(wlast == (beat == 15), "R2 wlast", wlast, beat == 15);
        check(&wstrb, "R2 wstrb", wstrb, '1);
        if (wready) begin
          logic [DW-1:0] ed;
          ed = pat((m_k % (1 << BLKW)) * 16 + beat);
          check(wdata == ed, "R5 wdata", wdata, ed);
          beat++;
          if (beat == 16) begin
            aw_open = 0; open_b = 1; m_k++;
            b_pend++; b_wait = throttle ? int'($urandom % 4) : 0;
          end
        end
      end
      if (bvalid && bready) begin
        b_took = 1; open_b = 0;
        if (bresp != 2'b00) n_err = 1;
        m_bk++;
        if (m_bk == m_nb) begin n_done = 1; nb_busy = 0; end
      end
      m_busy = nb_busy; exp_done = n_done; exp_err = n_err;
      pw_v = wvalid; pw_r = wready; pw_d = wdata;
      pa_v = awvalid; pa_r = awready; pa_a = awaddr;
    end
  end

  task automatic run(logic [31:0] a, logic [31:0] len);
    @(negedge clk);
    start = 1; start_addr = a; length_bytes = len;
    @(negedge clk);
    start = 0;
    while (done !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1 reset state", {busy, done, err}, 0);
    check(!awvalid && !wvalid && !buf_rd_en, "R5 reset quiet", {awvalid, wvalid, buf_rd_en}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(32'h0000_1000, 32'h400);
    throttle = 1;
    run(32'h0000_2345, 32'h2A0);
    coh_cache = 4'hF; coh_user = 5'h1F;
    fork
      run(32'hBFFF_FE00, 32'h400);
      begin repeat (10) @(negedge clk); coh_cache = 4'h5; coh_user = 5'h0A; end
    join
    b_issued = 0; err_at = 3;
    fork
      run(32'h0004_0000, 32'hA00);
      begin repeat (30) @(negedge clk); start = 1; start_addr = 32'h9000_0000; length_bytes = 32'h100; @(negedge clk); start = 0; end
    join
    check(err === 1'b1, "R9 err sticky", err, 1);
    err_at = -1;
    run(32'h0000_5000, 32'h80);
    check(err === 1'b0, "R9 err cleared", err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule